// File: doc/BRIEF.md
# Five-Line Prioritized Interrupt Controller

This block takes five interrupt request lines, each with its own trigger style, and offers the highest-ranked eligible one to a processor. For each of the four top-ranked lines it drives a fixed 16-bit service address. For the lowest-ranked line it raises an external-vector flag instead, and after acceptance it pulses an acknowledge so that the requesting device can place its own vector on the bus.

The top line cannot be disabled. It is detected by a rising edge, and it stays pending only while the line is held high. The next line down is edge-latched. The remaining three are level sensitive. The four lower lines are gated by a global enable flag, which is set and cleared by single-cycle strobes. The three middle lines can also be masked one by one through a mask-write strobe with a data nibble. A status view of the raw per-line activity, the mask and the enable flag is always visible.

The processor samples `int_o` and `vec_o` and pulses `ack_i` for one cycle when it takes the interrupt. Stack handling and the jump itself belong to the processor.

Top module: `pic5_ctrl`

## Requirements
- R1: After reset the enable flag is 0, all three mask bits read 1, `pend_o` is 0 and `int_o` is 0.
- R2: Line ranking from highest to lowest is req_i[4], req_i[3], req_i[2], req_i[1], req_i[0]. When several lines are eligible, the highest-ranked one is selected.
- R3: The service addresses are 0x0024 for line 4, 0x003C for line 3, 0x0034 for line 2 and 0x002C for line 1. `vec_o` is 0 when line 0 or no line is selected.
- R4: When line 0 is selected, `ext_o` is 1 and `vec_o` is 0. An accepted acknowledge of line 0 makes `ext_ack_o` high for exactly the one cycle after the acknowledge edge.
- R5: Lines 0 to 3 are eligible only while the enable flag is 1. `ien_set_i` sets the flag and `ien_clr_i` clears it, and clear wins when both strobes arrive in the same cycle.
- R6: A `mask_wr_i` strobe loads mask bits from `mask_data_i[2:0]`: bit 0 masks line 1, bit 1 masks line 2 and bit 2 masks line 3, where 1 means masked. Lines 0 and 4 ignore the mask.
- R7: Line 4 ignores both the enable flag and the mask. It becomes pending on a rising edge, it stops being pending as soon as the line falls, and it needs a fresh rising edge to become pending again.
- R8: A rising edge on line 3 is latched even while the line is masked or disabled. The latch holds until line 3 is serviced, or until a mask write with `mask_data_i[3]` = 1 clears it.
- R9: Lines 1 and 2 follow their input level with no memory. Dropping the level removes the request in the same cycle.
- R10: An accepted acknowledge (`ack_i` while `int_o` is 1) clears the enable flag. When the accepted line is 4 or 3, it also clears that line's latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 5 | Request lines; bit 4 ranks highest |
| ien_set_i | input | 1 | Strobe that sets the global enable |
| ien_clr_i | input | 1 | Strobe that clears the global enable |
| mask_wr_i | input | 1 | Mask-write strobe |
| mask_data_i | input | 4 | [2:0] new mask bits, [3] clears the line-3 latch |
| ack_i | input | 1 | Processor accepts the current selection |
| int_o | output | 1 | An eligible request exists |
| vec_o | output | 16 | Service address of the selected line |
| ext_o | output | 1 | The selected line supplies its own vector |
| ext_ack_o | output | 1 | One-cycle acknowledge to the external-vector device |
| pend_o | output | 5 | Raw per-line activity before gating |
| mask_o | output | 3 | Current mask bits |
| ien_o | output | 1 | Current global enable |

## Verification
The embedded properties check several rules on every cycle. The top line always wins with address 0x0024 while it is active. Nothing but the top line can raise `int_o` while the enable flag is low. Acceptance drops the enable flag on the next cycle. The external acknowledge follows only an accepted external selection. The mask holds between writes, and a latched line-3 edge persists until one of its two clearing events. Other behaviours appear only in the directed scenarios: the full ranking and address table, that edges are captured while a line is masked, the need for a fresh rising edge on the top line after service, and clear-wins when both enable strobes coincide.

// File: rtl/pic5_pkg.sv
package pic5_pkg;

    localparam int NLINE     = 5;
    localparam int IDX_W     = $clog2(NLINE);
    localparam int VEC_W     = 16;
    localparam int MASK_W    = 3;
    localparam int CFG_W     = MASK_W + 1;
    localparam int LINE_CRIT = 4;
    localparam int LINE_EDGE = 3;
    localparam int LINE_MID  = 2;
    localparam int LINE_LO   = 1;
    localparam int LINE_EXT  = 0;

    typedef enum logic [1:0] {
        TRG_LEVEL,
        TRG_EDGE,
        TRG_BOTH
    } trig_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    function automatic trig_e trig_of(input int line);
        if (line == LINE_CRIT)      return TRG_BOTH;
        else if (line == LINE_EDGE) return TRG_EDGE;
        else                        return TRG_LEVEL;
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        case (idx)
            IDX_W'(LINE_CRIT): return VEC_W'(16'h0024);
            IDX_W'(LINE_EDGE): return VEC_W'(16'h003C);
            IDX_W'(LINE_MID):  return VEC_W'(16'h0034);
            IDX_W'(LINE_LO):   return VEC_W'(16'h002C);
            default:           return '0;
        endcase
    endfunction

    // Highest index wins: later iterations overwrite earlier ones.
    function automatic pick_t pick_top(input logic [NLINE-1:0] elig);
        pick_t p;
        p = '0;
        for (int i = 0; i < NLINE; i++) begin
            if (elig[i]) begin
                p.hit = 1'b1;
                p.idx = IDX_W'(i);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/pic5_trig.sv
module pic5_trig
    import pic5_pkg::*;
#(
    parameter trig_e KIND = TRG_LEVEL
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic clr_i,
    output logic act_o
);

    logic prev_q;
    logic lat_q;
    logic rise;

    assign rise = req_i & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            lat_q  <= 1'b0;
        end else begin
            prev_q <= req_i;
            if (rise)
                lat_q <= 1'b1;
            else if (clr_i || (KIND == TRG_BOTH && !req_i))
                lat_q <= 1'b0;
        end
    end

    assign act_o = (KIND == TRG_LEVEL) ? req_i :
                   (KIND == TRG_EDGE)  ? lat_q :
                                         (lat_q & req_i);

    // R8
    edge_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (rise && KIND != TRG_LEVEL) |=> act_o || !req_i || KIND == TRG_EDGE && act_o);

    // R7
    both_needs_level_chk: assert property (@(posedge clk) disable iff (rst)
        (KIND == TRG_BOTH && act_o) |-> req_i);

endmodule

// File: rtl/pic5_arb.sv
module pic5_arb
    import pic5_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NLINE-1:0] elig_i,
    output pick_t            pick_o,
    output logic [NLINE-1:0] grant_o
);

    assign pick_o = pick_top(elig_i);

    generate
        for (genvar g = 0; g < NLINE; g++) begin : g_grant
            assign grant_o[g] = pick_o.hit && (pick_o.idx == IDX_W'(g));
        end
    endgenerate

    // R2
    single_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o) && ((|elig_i) == (|grant_o)));

    // R2
    grant_is_eligible_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_o & ~elig_i) == '0);

endmodule

// File: rtl/pic5_ctrl.sv
module pic5_ctrl
    import pic5_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINE-1:0]  req_i,
    input  logic              ien_set_i,
    input  logic              ien_clr_i,
    input  logic              mask_wr_i,
    input  logic [CFG_W-1:0]  mask_data_i,
    input  logic              ack_i,
    output logic              int_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              ext_o,
    output logic              ext_ack_o,
    output logic [NLINE-1:0]  pend_o,
    output logic [MASK_W-1:0] mask_o,
    output logic              ien_o
);

    logic [NLINE-1:0]  act;
    logic [NLINE-1:0]  clr;
    logic [NLINE-1:0]  elig;
    logic [NLINE-1:0]  grant;
    logic [MASK_W-1:0] mask_q;
    logic              ien_q;
    logic              ext_ack_q;
    logic              take;
    pick_t             pick;

    generate
        for (genvar g = 0; g < NLINE; g++) begin : g_line
            assign clr[g] = (take && pick.idx == IDX_W'(g)) ||
                            (g == LINE_EDGE && mask_wr_i && mask_data_i[CFG_W-1]);
            pic5_trig #(.KIND(trig_of(g))) trig_i (
                .clk   (clk),
                .rst   (rst),
                .req_i (req_i[g]),
                .clr_i (clr[g]),
                .act_o (act[g])
            );
        end
    endgenerate

    always_comb begin
        elig[LINE_CRIT] = act[LINE_CRIT];
        elig[LINE_EDGE] = act[LINE_EDGE] & ien_q & ~mask_q[2];
        elig[LINE_MID]  = act[LINE_MID]  & ien_q & ~mask_q[1];
        elig[LINE_LO]   = act[LINE_LO]   & ien_q & ~mask_q[0];
        elig[LINE_EXT]  = act[LINE_EXT]  & ien_q;
    end

    pic5_arb arb_i (
        .clk     (clk),
        .rst     (rst),
        .elig_i  (elig),
        .pick_o  (pick),
        .grant_o (grant)
    );

    assign take = ack_i & pick.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q     <= 1'b0;
            mask_q    <= '1;
            ext_ack_q <= 1'b0;
        end else begin
            if (take)           ien_q <= 1'b0;
            else if (ien_clr_i) ien_q <= 1'b0;
            else if (ien_set_i) ien_q <= 1'b1;
            if (mask_wr_i)
                mask_q <= mask_data_i[MASK_W-1:0];
            ext_ack_q <= take && grant[LINE_EXT];
        end
    end

    assign int_o     = pick.hit;
    assign vec_o     = pick.hit ? vec_of(pick.idx) : '0;
    assign ext_o     = grant[LINE_EXT];
    assign ext_ack_o = ext_ack_q;
    assign pend_o    = act;
    assign mask_o    = mask_q;
    assign ien_o     = ien_q;

    // R7
    crit_wins_chk: assert property (@(posedge clk) disable iff (rst)
        act[LINE_CRIT] |-> (int_o && vec_o == 16'h0024 && !ext_o));

    // R5
    gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!ien_o && !act[LINE_CRIT]) |-> !int_o);

    // R10
    ack_drops_ien_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && int_o) |=> !ien_o);

    // R4
    ext_ack_chk: assert property (@(posedge clk) disable iff (rst)
        ext_ack_o |-> $past(ack_i && ext_o));

    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mask_wr_i |=> $stable(mask_o));

    // R8
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (act[LINE_EDGE] && !(ack_i && ext_o == 1'b0 && vec_o == 16'h003C) &&
         !(mask_wr_i && mask_data_i[CFG_W-1])) |=> act[LINE_EDGE]);

endmodule

// File: tb/pic5_ctrl_tb_top.sv
`timescale 1ns/1ps
module pic5_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  req_i = '0;
    logic        ien_set_i = 1'b0;
    logic        ien_clr_i = 1'b0;
    logic        mask_wr_i = 1'b0;
    logic [3:0]  mask_data_i = '0;
    logic        ack_i = 1'b0;
    logic        int_o;
    logic [15:0] vec_o;
    logic        ext_o;
    logic        ext_ack_o;
    logic [4:0]  pend_o;
    logic [2:0]  mask_o;
    logic        ien_o;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pic5_ctrl dut_i (
        .clk(clk), .rst(rst), .req_i(req_i),
        .ien_set_i(ien_set_i), .ien_clr_i(ien_clr_i),
        .mask_wr_i(mask_wr_i), .mask_data_i(mask_data_i),
        .ack_i(ack_i), .int_o(int_o), .vec_o(vec_o), .ext_o(ext_o),
        .ext_ack_o(ext_ack_o), .pend_o(pend_o), .mask_o(mask_o), .ien_o(ien_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", rq, got, exp);
        end
    endtask

    task automatic enable();
        ien_set_i = 1'b1; tick(); ien_set_i = 1'b0;
    endtask

    task automatic setmask(input logic [3:0] d);
        mask_wr_i = 1'b1; mask_data_i = d; tick(); mask_wr_i = 1'b0;
    endtask

    task automatic accept();
        ack_i = 1'b1; tick(); ack_i = 1'b0;
    endtask

    task automatic clean();
        req_i = '0;
        ien_clr_i = 1'b1; tick(); ien_clr_i = 1'b0;
        setmask(4'hF);
        tick();
    endtask

    task automatic t_reset();
        chk("R1 ien", 32'(ien_o), 0);
        chk("R1 mask", 32'(mask_o), 7);
        chk("R1 pend", 32'(pend_o), 0);
        chk("R1 int", 32'(int_o), 0);
    endtask

    task automatic t_level();
        clean(); setmask(4'h0); enable();
        req_i[1] = 1'b1; #1;
        chk("R9 level on", 32'(int_o), 1);
        chk("R3 line1 addr", 32'(vec_o), 32'h002C);
        req_i[1] = 1'b0; #1;
        chk("R9 level off", 32'(int_o), 0);
        chk("R9 no memory", 32'(pend_o[1]), 0);
    endtask

    task automatic t_priority();
        clean(); setmask(4'h0); enable();
        req_i = 5'b00011; #1;
        chk("R2 line1 over line0", 32'(vec_o), 32'h002C);
        req_i = 5'b00111; #1;
        chk("R2 line2 wins", 32'(vec_o), 32'h0034);
        req_i[3] = 1'b1; tick();
        chk("R2 line3 wins", 32'(vec_o), 32'h003C);
        req_i[3] = 1'b0;
        req_i[4] = 1'b1; tick();
        chk("R2 line4 wins", 32'(vec_o), 32'h0024);
        chk("R3 no ext flag", 32'(ext_o), 0);
    endtask

    task automatic t_ext();
        clean(); setmask(4'h0); enable();
        req_i = 5'b00001; #1;
        chk("R4 ext flag", 32'(ext_o), 1);
        chk("R4 ext addr zero", 32'(vec_o), 0);
        chk("R4 int", 32'(int_o), 1);
        accept();
        chk("R4 ack pulse", 32'(ext_ack_o), 1);
        chk("R10 ien cleared", 32'(ien_o), 0);
        chk("R5 blocked after ack", 32'(int_o), 0);
        tick();
        chk("R4 ack one cycle", 32'(ext_ack_o), 0);
    endtask

    task automatic t_enable();
        clean(); setmask(4'h0);
        req_i[2] = 1'b1; #1;
        chk("R5 disabled blocks", 32'(int_o), 0);
        enable();
        chk("R5 set", 32'(int_o), 1);
        ien_set_i = 1'b1; ien_clr_i = 1'b1; tick();
        ien_set_i = 1'b0; ien_clr_i = 1'b0;
        chk("R5 clear wins", 32'(ien_o), 0);
        chk("R5 int gone", 32'(int_o), 0);
    endtask

    task automatic t_mask();
        clean(); setmask(4'h1); enable();
        chk("R6 mask value", 32'(mask_o), 1);
        req_i[1] = 1'b1; #1;
        chk("R6 line1 masked", 32'(int_o), 0);
        req_i[2] = 1'b1; #1;
        chk("R6 line2 open", 32'(vec_o), 32'h0034);
        setmask(4'h6);
        chk("R6 remask", 32'(vec_o), 32'h002C);
        setmask(4'h7);
        req_i = 5'b00001; #1;
        chk("R6 line0 unmaskable", 32'(ext_o), 1);
    endtask

    task automatic t_edge();
        clean();
        req_i[3] = 1'b1; tick(); req_i[3] = 1'b0; tick();
        chk("R8 captured while masked", 32'(pend_o[3]), 1);
        chk("R8 not offered", 32'(int_o), 0);
        setmask(4'h3);
        chk("R5 still disabled", 32'(int_o), 0);
        enable();
        chk("R8 offered", 32'(vec_o), 32'h003C);
        accept();
        chk("R10 latch cleared", 32'(pend_o[3]), 0);
        chk("R10 ien cleared", 32'(ien_o), 0);
        req_i[3] = 1'b1; tick(); req_i[3] = 1'b0; tick();
        chk("R8 relatch", 32'(pend_o[3]), 1);
        setmask(4'h8);
        chk("R8 cleared by mask write", 32'(pend_o[3]), 0);
    endtask

    task automatic t_trap();
        clean();
        req_i[4] = 1'b1; tick();
        chk("R7 ignores enable and mask", 32'(int_o), 1);
        chk("R7 addr", 32'(vec_o), 32'h0024);
        accept();
        chk("R10 crit latch cleared", 32'(pend_o[4]), 0);
        chk("R7 held high no retrigger", 32'(int_o), 0);
        req_i[4] = 1'b0; tick();
        req_i[4] = 1'b1; tick();
        chk("R7 fresh edge", 32'(pend_o[4]), 1);
        req_i[4] = 1'b0; #1;
        chk("R7 drop removes", 32'(pend_o[4]), 0);
        tick(); req_i[4] = 1'b1; #1;
        chk("R7 level alone insufficient", 32'(pend_o[4]), 0);
        req_i[4] = 1'b0;
    endtask

    initial begin
        tick(); tick(); tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_level();
        t_priority();
        t_ext();
        t_enable();
        t_mask();
        t_edge();
        t_trap();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: got hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule